// File: doc/BRIEF.md
# Polled Character Display Output Port

This block lets a 16-bit processor send characters to a display through two registers on its memory bus. A status register at 0xF3FC carries a ready flag in bit 15, so software can load the status word and branch on its sign to tell whether the port can take a character. Writing the data register at 0xF3FF stores the low byte of the write data as the next character and clears the ready flag.

The stored character is offered to a character sink on `char_valid`/`char_code`. It stays offered until the sink raises `char_ack`. The port holds one character at most. Any write to the data register while the port is busy is dropped without trace, and the earlier character is kept. Bus accesses take one cycle each. Read data is combinational from the address and read strobe. Addresses other than the two registers leave the port untouched and read as zero.

Top module: `disp_out_port`

## Requirements
- R1: A read (`re`=1) at address 0xF3FC returns the ready flag in bit 15 (1 = can accept a character). Bits [14:0] read as zero.
- R2: A read at address 0xF3FF returns the last accepted character in bits [7:0], with bits [15:8] zero.
- R3: After reset the ready flag is 1, the stored character is 0x00 and `char_valid` is 0.
- R4: A write (`we`=1) at 0xF3FF while ready stores `wdata[7:0]`. From the next cycle the ready flag reads 0, and `char_valid`=1 with `char_code` equal to the stored byte.
- R5: A write at 0xF3FF while not ready is ignored. The stored character, `char_code` and `char_valid` are unchanged.
- R6: `char_valid` stays high until `char_ack` is sampled high. In the following cycle `char_valid` is 0 and the ready flag reads 1.
- R7: `char_ack` while `char_valid` is 0 has no effect.
- R8: Reads at any address other than 0xF3FC and 0xF3FF return zero. Writes there, including a write to 0xF3FC, change nothing.
- R9: `rdata` is zero whenever `re` is 0.
- R10: A read in the same cycle as a state change returns the value from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Bus address |
| wdata | input | 16 | Bus write data |
| we | input | 1 | Write strobe, one cycle |
| re | input | 1 | Read strobe, one cycle |
| rdata | output | 16 | Read data, combinational |
| char_valid | output | 1 | A character is offered to the sink |
| char_code | output | 8 | Offered character |
| char_ack | input | 1 | Sink has taken the character |

## Verification
Two functions can fall in the same cycle. The first is a bus read and a state change: a data-register read during an accepted write, and a status read during the sink's acknowledge. The bench drives `re` and `we` together on the data register. It also raises `char_ack` while polling status. In both cases it expects `rdata` to show the state from before the edge. The model then expects the new state on the next cycle. The second overlap is a write attempt against a busy port. Such a write is checked both on `char_code` and through a later read of the data register.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned CHAR_W  = 8;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hF3FC;
  localparam logic [BUS_W-1:0] DATA_ADDR = 16'hF3FF;
  localparam int unsigned RDY_BIT = BUS_W - 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/disp_addr_dec.sv
module disp_addr_dec
  import disp_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_W,
  parameter logic [ADDR_W-1:0] STAT_A = STAT_ADDR,
  parameter logic [ADDR_W-1:0] DATA_A = DATA_ADDR
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == STAT_A)      sel = SEL_STAT;
    else if (addr == DATA_A) sel = SEL_DATA;
    else                     sel = SEL_NONE;
  end
endmodule

// File: rtl/disp_hs_ctrl.sv
module disp_hs_ctrl #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [CW-1:0] wchar,
  input  logic          ack,
  output logic          busy,
  output logic [CW-1:0] char_q
);
  logic busy_q, busy_d;
  logic load;

  always_comb begin
    load   = wr_data && !busy_q;
    busy_d = busy_q;
    if (load)              busy_d = 1'b1;
    else if (busy_q && ack) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    char_q <= '0;
    else if (load) char_q <= wchar;
  end

  assign busy = busy_q;
endmodule

// File: rtl/disp_rd_mux.sv
module disp_rd_mux
  import disp_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned CW = CHAR_W,
  parameter int unsigned RB = DW - 1
) (
  input  logic          re,
  input  reg_sel_e      sel,
  input  logic          ready,
  input  logic [CW-1:0] char_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] stat_word, data_word;

  always_comb begin
    stat_word     = '0;
    stat_word[RB] = ready;
    data_word     = '0;
    data_word[CW-1:0] = char_q;
  end

  always_comb begin
    rdata = '0;
    if (re) begin
      case (sel)
        SEL_STAT: rdata = stat_word;
        SEL_DATA: rdata = data_word;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/disp_out_port.sv
module disp_out_port
  import disp_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned CW = CHAR_W,
  parameter logic [DW-1:0] STAT_A = STAT_ADDR,
  parameter logic [DW-1:0] DATA_A = DATA_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  output logic [DW-1:0] rdata,
  output logic          char_valid,
  output logic [CW-1:0] char_code,
  input  logic          char_ack
);
  localparam int unsigned RB = DW - 1;

  logic     rst_n_sync;
  reg_sel_e sel;
  logic     busy;
  logic [CW-1:0] char_q;
  logic     unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:CW];

  disp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  disp_addr_dec #(.ADDR_W(DW), .STAT_A(STAT_A), .DATA_A(DATA_A)) u_dec (
    .addr(addr), .sel(sel)
  );

  disp_hs_ctrl #(.CW(CW)) u_hs (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_data(we && (sel == SEL_DATA)),
    .wchar(wdata[CW-1:0]),
    .ack(char_ack),
    .busy(busy), .char_q(char_q)
  );

  disp_rd_mux #(.DW(DW), .CW(CW), .RB(RB)) u_mux (
    .re(re), .sel(sel), .ready(!busy), .char_q(char_q), .rdata(rdata)
  );

  assign char_valid = busy;
  assign char_code  = char_q;
endmodule

// File: rtl/disp_out_port_chk.sv
module disp_out_port_chk
  import disp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [15:0] wdata,
  input logic        we,
  input logic        re,
  input logic [15:0] rdata,
  input logic        char_valid,
  input logic [7:0]  char_code,
  input logic        char_ack
);
  assert_stat_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == STAT_ADDR) |-> (rdata[15] == !char_valid && rdata[14:0] == 15'd0));

  assert_data_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == DATA_ADDR) |-> (rdata == {8'd0, char_code}));

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == DATA_ADDR && !char_valid) |=> (char_valid && char_code == $past(wdata[7:0])));

  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ack) |=> (char_valid && $stable(char_code)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_ack) |=> !char_valid);

  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_valid && !(we && addr == DATA_ADDR)) |=> (!char_valid && $stable(char_code)));

  assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr != STAT_ADDR && addr != DATA_ADDR) |-> (rdata == 16'd0));

  assert_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !re |-> (rdata == 16'd0));
endmodule

bind disp_out_port disp_out_port_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .addr(addr), .wdata(wdata), .we(we), .re(re),
  .rdata(rdata), .char_valid(char_valid), .char_code(char_code), .char_ack(char_ack)
);

// File: tb/sim_disp_out_port.sv
`timescale 1ns/1ps
module sim_disp_out_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr, wdata, rdata;
  logic        we, re, char_ack, char_valid;
  logic [7:0]  char_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit       m_busy;
  bit [7:0] m_char;

  always #4 clk = ~clk;

  disp_out_port u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .char_valid(char_valid), .char_code(char_code), .char_ack(char_ack)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] a, input bit r);
    if (!r)               return 16'h0000;
    if (a == 16'hF3FC)    return {!m_busy, 15'd0};
    if (a == 16'hF3FF)    return {8'd0, m_char};
    return 16'h0000;
  endfunction

  // One bus cycle: drive at negedge, compare against model, advance model at posedge.
  task automatic cyc(input string req, input logic [15:0] a, input logic [15:0] wd,
                     input bit w, input bit r, input bit k);
    @(negedge clk);
    addr = a; wdata = wd; we = w; re = r; char_ack = k;
    #1;
    chk(req, "rdata", rdata, exp_rd(a, r));
    chk(req, "char_valid", {15'd0, char_valid}, {15'd0, m_busy});
    chk(req, "char_code", {8'd0, char_code}, {8'd0, m_char});
    @(posedge clk);
    if (w && a == 16'hF3FF && !m_busy) begin
      m_busy = 1; m_char = wd[7:0];
    end else if (m_busy && k) begin
      m_busy = 0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    addr = 0; wdata = 0; we = 0; re = 0; char_ack = 0;
    m_busy = 0; m_char = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // R3 reset state, R1 status, R2 data
    cyc("R3", 16'hF3FC, 0, 0, 1, 0);
    chk("R3", "ready after reset", rdata, 16'h8000);
    cyc("R2", 16'hF3FF, 0, 0, 1, 0);
    chk("R3", "char after reset", rdata, 16'h0000);
    // R4 accept write, upper bits dropped
    cyc("R4", 16'hF3FF, 16'hAB41, 1, 0, 0);
    cyc("R4", 16'hF3FC, 0, 0, 1, 0);
    chk("R4", "ready cleared", rdata, 16'h0000);
    chk("R4", "code", {8'd0, char_code}, 16'h0041);
    // R5 write while busy ignored
    cyc("R5", 16'hF3FF, 16'h0042, 1, 0, 0);
    cyc("R5", 16'hF3FF, 0, 0, 1, 0);
    chk("R5", "char kept", rdata, 16'h0041);
    // R6 delayed ack, status read same cycle as ack (R10)
    for (int i = 0; i < 3; i++) cyc("R6", 16'hF3FC, 0, 0, 1, 0);
    cyc("R10", 16'hF3FC, 0, 0, 1, 1);
    chk("R10", "status during ack", rdata, 16'h0000);
    cyc("R6", 16'hF3FC, 0, 0, 1, 0);
    chk("R6", "ready after ack", rdata, 16'h8000);
    // R7 ack while idle
    cyc("R7", 16'h0000, 0, 0, 0, 1);
    cyc("R7", 16'hF3FC, 0, 0, 1, 1);
    chk("R7", "still ready", rdata, 16'h8000);
    // R8 other addresses
    cyc("R8", 16'hF3FC, 16'h0055, 1, 0, 0);
    cyc("R8", 16'hF3FE, 16'h0056, 1, 1, 0);
    chk("R8", "other read", rdata, 16'h0000);
    cyc("R8", 16'hF400, 16'h0057, 1, 1, 0);
    cyc("R8", 16'hF3FF, 0, 0, 1, 0);
    chk("R8", "char unchanged", rdata, 16'h0041);
    // R9 no strobe
    cyc("R9", 16'hF3FC, 0, 0, 0, 0);
    chk("R9", "rdata idle", rdata, 16'h0000);
    // R10 read and write together on data register
    cyc("R10", 16'hF3FF, 16'h0063, 1, 1, 0);
    chk("R10", "old char on read", rdata, 16'h0041);
    cyc("R10", 16'hF3FF, 0, 0, 1, 1);
    chk("R10", "new char", rdata, 16'h0063);
    // stream of characters with varying ack delay
    for (int n = 0; n < 8; n++) begin
      cyc("R4", 16'hF3FF, 16'(16'h0070 + n * 16'h0111), 1, 0, 0);
      for (int d = 0; d < (n % 3); d++) cyc("R5", 16'hF3FF, 16'h00EE, 1, 0, 0);
      cyc("R6", 16'hF3FC, 0, 0, 1, 1);
    end
    cyc("R6", 16'hF3FC, 0, 0, 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule